// File: doc/BRIEF.md
# Bit Permute Doubleword Unit

This block is a 64-bit bit-gather stage for a processor datapath. One operand, the selector word, is split into eight byte-wide bit indices. The other operand, the source word, supplies the bits that those indices pick. Each in-range index copies one source bit into the result. An index of 64 or more yields a zero bit instead of wrapping. The eight picked bits are packed into the least significant byte of a 64-bit result, and the upper 56 bits are always zero.

Bit numbering follows the MSB-first convention throughout. Index value k names source bit 63-k in LSB-first terms. Lane 0 reads its index from the most significant byte of the selector word, and its picked bit lands in result bit 7. The gather itself is pure combinational logic. A parameter selects the output variant. With the registered variant, a one-cycle input strobe captures the result on the next rising edge and raises an output strobe for one cycle. With the pass-through variant, the result and the strobe follow the inputs directly.

Top module: `bperm_unit`

## Requirements
- R1: Lane g (0..7) takes its 8-bit index from `sel_word[63-8g:56-8g]`, so lane 0 uses the most significant byte and lane 7 uses the least significant byte.
- R2: An index k below 64 copies `src_word[63-k]` into result bit `7-g` of lane g.
- R3: An index of 64 or more (either of the top two bits of the index byte is set) puts a 0 into that lane's result bit. This covers the values 64, 127 and 255.
- R4: `result[63:8]` is zero for every input.
- R5: Lanes work independently, so two or more lanes may hold the same index and each then reads the same source bit.
- R6: In the registered variant (`REG_OUT=1`), a high `in_valid` at a rising edge loads the gathered result into `result` and drives `out_valid` high for the following cycle only.
- R7: In the registered variant, while `in_valid` is low, `result` keeps its value and any change on `sel_word` or `src_word` has no effect on it.
- R8: A high `rst` at a rising edge clears `result` to zero and `out_valid` to 0 (synchronous, active high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge is active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe marking the operands as valid this cycle |
| sel_word | input | 64 | Eight packed 8-bit bit indices, lane 0 in the top byte |
| src_word | input | 64 | Source word whose bits are gathered |
| out_valid | output | 1 | One-cycle strobe showing that `result` was just loaded |
| result | output | 64 | Gathered bits in [7:0]; [63:8] are zero |

## Verification
The clocked properties assume that `rst`, `in_valid` and both operands are stable and known around each rising edge. They also assume that `rst` is a plain synchronous level and not a glitch between edges. The lane properties take the operands as two-state values, so an unknown index never reaches the range check. The bench meets all of this by changing inputs only on falling edges, driving every operand bit to a defined 0 or 1, and holding reset across whole cycles.

// File: rtl/bperm_pkg.sv
package bperm_pkg;
  localparam int BP_DATA_W = 64;
  localparam int BP_LANES  = 8;
  localparam int BP_IDX_W  = 8;
  localparam int BP_SEL_W  = $clog2(BP_DATA_W);

  // Index byte for lane g, MSB-first: lane 0 is the top byte
  function automatic logic [BP_IDX_W-1:0] lane_index(input logic [BP_DATA_W-1:0] word,
                                                     input int unsigned g);
    logic [BP_DATA_W-1:0] sh;
    sh = word >> (BP_DATA_W - BP_IDX_W * (g + 1));
    return sh[BP_IDX_W-1:0];
  endfunction

  // An index is usable only when every bit above the select field is clear
  function automatic logic index_in_range(input logic [BP_IDX_W-1:0] idx);
    return idx[BP_IDX_W-1:BP_SEL_W] == '0;
  endfunction
endpackage

// File: rtl/bperm_idx_decode.sv
module bperm_idx_decode #(
  parameter int IDX_W = bperm_pkg::BP_IDX_W,
  parameter int SEL_W = bperm_pkg::BP_SEL_W
) (
  input  logic [IDX_W-1:0] idx,
  output logic             in_range,
  output logic [SEL_W-1:0] sel
);
  assign in_range = bperm_pkg::index_in_range(idx);
  assign sel      = idx[SEL_W-1:0];
endmodule

// File: rtl/bperm_bit_mux.sv
module bperm_bit_mux #(
  parameter int DATA_W = bperm_pkg::BP_DATA_W,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] rev_data,   // bit k here is MSB-first bit k of the source
  input  logic [SEL_W-1:0]  sel,
  input  logic              in_range,
  output logic              pick
);
  logic raw_bit;
  assign raw_bit = rev_data[sel];
  assign pick    = in_range & raw_bit;

  // R3
  always_comb begin
    if (!in_range) oor_zero_chk: assert (pick == 1'b0);
  end
endmodule

// File: rtl/bperm_core.sv
module bperm_core #(
  parameter int DATA_W = bperm_pkg::BP_DATA_W,
  parameter int LANES  = bperm_pkg::BP_LANES,
  parameter int IDX_W  = bperm_pkg::BP_IDX_W,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] sel_word,
  input  logic [DATA_W-1:0] src_word,
  output logic [DATA_W-1:0] gathered
);
  logic [DATA_W-1:0] rev_src;
  logic [LANES-1:0]  lane_pick;
  logic [LANES-1:0]  lane_ok;

  assign rev_src = {<<{src_word}};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IDX_W-1:0] idx;
    logic [SEL_W-1:0] sel;
    assign idx = sel_word[DATA_W-1-IDX_W*g -: IDX_W];   // R1

    bperm_idx_decode #(.IDX_W(IDX_W), .SEL_W(SEL_W)) u_dec (
      .idx(idx), .in_range(lane_ok[g]), .sel(sel)
    );
    bperm_bit_mux #(.DATA_W(DATA_W)) u_mux (
      .rev_data(rev_src), .sel(sel), .in_range(lane_ok[g]), .pick(lane_pick[g])
    );
    assign gathered[LANES-1-g] = lane_pick[g];           // R2: lane 0 -> top of low byte
  end

  assign gathered[DATA_W-1:LANES] = '0;                  // R4
endmodule

// File: rtl/bperm_unit.sv
module bperm_unit #(
  parameter int DATA_W  = bperm_pkg::BP_DATA_W,
  parameter int LANES   = bperm_pkg::BP_LANES,
  parameter int IDX_W   = bperm_pkg::BP_IDX_W,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] sel_word,
  input  logic [DATA_W-1:0] src_word,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] gathered;

  bperm_core #(.DATA_W(DATA_W), .LANES(LANES), .IDX_W(IDX_W)) u_core (
    .sel_word(sel_word), .src_word(src_word), .gathered(gathered)
  );

  if (REG_OUT) begin : g_reg
    logic [DATA_W-1:0] res_q;
    logic              vld_q;
    logic              load_evt;
    assign load_evt = in_valid;

    always_ff @(posedge clk) begin
      if (rst) begin
        res_q <= '0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= load_evt;
        if (load_evt) res_q <= gathered;
      end
    end
    assign result    = res_q;
    assign out_valid = vld_q;

    // R6
    strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    // R6
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(result));
    // R8
    rst_clear_chk: assert property (@(posedge clk)
      rst |=> (result == '0 && !out_valid));
    // R4
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
      result[DATA_W-1:LANES] == '0);
  end else begin : g_comb
    assign result    = gathered;
    assign out_valid = in_valid;
    // R4
    always_comb upper_zero_chk: assert (result[DATA_W-1:LANES] == '0);
  end
endmodule

// File: tb/sim_bperm_unit.sv
module sim_bperm_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] sel_word = '0;
  logic [63:0] src_word = '0;
  logic        out_valid;
  logic [63:0] result;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bperm_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .sel_word(sel_word), .src_word(src_word),
    .out_valid(out_valid), .result(result)
  );

  // Independent model: walk the MSB-first lanes and indices
  function automatic logic [63:0] model(input logic [63:0] s, input logic [63:0] d);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      int k = int'((s >> (56 - 8*i)) & 64'hFF);
      if (k < 64) r[7-i] = d[63-k];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Strobe one operand pair, check the capture, then check the hold while
  // the operands are scrambled with the strobe low.
  task automatic run_vec(input string tag, input logic [63:0] s, input logic [63:0] d);
    logic [63:0] exp = model(s, d);
    @(negedge clk);
    sel_word = s; src_word = d; in_valid = 1'b1;
    @(negedge clk);
    check({tag, " R6 out_valid"}, {63'd0, out_valid}, 64'd1);
    check(tag, result, exp);
    check({tag, " R4 upper"}, result & ~64'hFF, 64'd0);
    in_valid = 1'b0; sel_word = ~s; src_word = ~d;
    @(negedge clk);
    check({tag, " R6 pulse end"}, {63'd0, out_valid}, 64'd0);
    check({tag, " R7 hold"}, result, exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R8 reset result", result, 64'd0);
    check("R8 reset valid", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_all_zero();
    run_vec("R2 idx all 0 ones", 64'h0, 64'h8000_0000_0000_0000);
    run_vec("R2 idx all 0 zero", 64'h0, 64'h7FFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_all_63();
    run_vec("R2 idx all 63 ones", {8{8'd63}}, 64'h0000_0000_0000_0001);
    run_vec("R2 idx all 63 zero", {8{8'd63}}, 64'hFFFF_FFFF_FFFF_FFFE);
  endtask

  task automatic t_out_of_range();
    run_vec("R3 oor 64/127/255", {8'd64, 8'd127, 8'd255, 8'd0, 8'd64, 8'd127, 8'd255, 8'd63},
            64'hFFFF_FFFF_FFFF_FFFF);
    run_vec("R3 oor 128/192", {8'd128, 8'd192, 8'd128, 8'd192, 8'd128, 8'd192, 8'd128, 8'd192},
            64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_lane_position();
    // R1: one in-range lane at a time; it picks bit 63-5 = 1, others are out of range
    for (int g = 0; g < 8; g++) begin
      logic [63:0] s = {8{8'hFF}};
      s[63-8*g -: 8] = 8'd5;
      run_vec($sformatf("R1 lane %0d", g), s, 64'h0400_0000_0000_0000);
    end
  endtask

  task automatic t_duplicates();
    run_vec("R5 dup 17", {8{8'd17}}, 64'h0000_4000_0000_0000);
    run_vec("R5 dup pairs", {8'd2, 8'd2, 8'd40, 8'd40, 8'd2, 8'd40, 8'd9, 8'd9},
            64'h2000_0000_0080_0000);
  endtask

  task automatic t_random();
    for (int n = 0; n < 200; n++) begin
      logic [63:0] s = {$urandom, $urandom};
      logic [63:0] d = {$urandom, $urandom};
      if (n % 2 == 0) s = s & {8{8'h3F}};
      run_vec("R2 R3 random", s, d);
    end
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    sel_word = {8{8'd0}}; src_word = 64'h8000_0000_0000_0000; in_valid = 1'b1;
    @(negedge clk);
    check("R8 pre-reset load", result, 64'hFF);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R8 mid reset result", result, 64'd0);
    check("R8 mid reset valid", {63'd0, out_valid}, 64'd0);
    rst = 1'b0; in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_all_zero();
    t_all_63();
    t_out_of_range();
    t_lane_position();
    t_duplicates();
    t_random();
    t_mid_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=finished");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule